// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash device and drives the device's chip-enable, output-enable and write-enable pins. A client hands it one request at a time over a valid/ready handshake. The four requests are: read a byte, program a byte, erase the whole chip, and turn on the boot-area write lockout. Each program, erase or lockout request is turned into a fixed train of command write cycles. The train always opens with the two unlock writes, 0xAA to 0x5555 and then 0x55 to 0x2AAA.

When a program or erase has been issued, the sequencer reads the device again and again. It watches data bit 7 until the device reports that the operation has finished, or until a parameterized number of reads has passed. A program request first reads the target byte. If the new value would need any bit to go from 0 back to 1, the request is refused and no command is written. Each request ends with a single response pulse that carries a byte and an error code.

All strobe timing is counted in system clock cycles: address/data setup before the strobe falls, strobe low time, and hold after the strobe rises. Each of these is at least one cycle.

Top module: `flash_seq`

## Requirements
- R1: A request with op code 0 (read) performs exactly one bus read of `req_addr` and no write. The response returns the byte read, with error code 0.
- R2: `fl_we_n` and `fl_oe_n` are never low together. Either strobe is low only while `fl_ce_n` is low. A read strobe has `fl_oe_n` low and `fl_we_n` high.
- R3: The host drives the data bus (`fl_dq_oe` = 1) only during write cycles. It never drives the bus while `fl_oe_n` is low or while `fl_ce_n` is high.
- R4: In every write cycle, address and data are stable and driven for at least one cycle before `fl_we_n` falls. They remain stable and driven in the cycle in which `fl_we_n` rises.
- R5: An accepted program request (op code 1) starts with one read of the target byte. It then issues exactly 4 writes, in this order: 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, data@target.
- R6: A chip erase (op code 2) issues exactly 6 writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555. A lockout (op code 3) issues the same six writes, except that the last data byte is 0x40. A lockout then responds with error 0 and data 0, and performs no read.
- R7: If the byte to be programmed has a 1 where the pre-read byte has a 0, the response carries error code 1 and the pre-read byte, and no write is issued.
- R8: After the command writes of a program or erase, the sequencer reads `req_addr` until read bit 7 equals the wanted value. The wanted value is data bit 7 for a program and 1 for an erase. The response then carries error code 0 and the last byte read. A match on the final allowed read counts as success.
- R9: If `MAX_POLLS` poll reads pass without a match, the response carries error code 2, after exactly `MAX_POLLS` poll reads.
- R10: `req_ready` is high only while the sequencer is idle. Every accepted request yields exactly one single-cycle `rsp_valid` pulse. No new request is taken before that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 2 | 0 read, 1 program, 2 chip erase, 3 boot lockout |
| req_addr | input | AW | Target byte address (also the poll address) |
| req_data | input | 8 | Byte to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read byte, last poll byte, or pre-read byte on refusal |
| rsp_err | output | 2 | 0 none, 1 would raise a bit, 2 poll timeout |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Host drives the data bus |
| fl_dq_in | input | 8 | Data returned by the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
Two outcomes can fall on the same poll read: the match on bit 7 and the expiry of the poll limit. The bench provokes this by setting the flash model's busy length to `MAX_POLLS - 1`, so that the first matching read is also the last allowed one. It expects error 0 in that case. With a busy length of exactly `MAX_POLLS`, it expects error 2, and in both cases it expects `MAX_POLLS` poll reads. Around these two cases, a sweep of old/new byte pairs checks that the refusal rule and the programmed value are computed as AND-ing the new value into the old.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_LOCK  = 2'd3
  } op_e;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_RAISE   = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

  localparam logic [15:0] CODE_ADDR_A = 16'h5555;
  localparam logic [15:0] CODE_ADDR_B = 16'h2AAA;

  // number of command writes an operation needs
  function automatic logic [2:0] cmd_len(op_e op);
    case (op)
      OP_PROG:  return 3'd4;
      OP_ERASE: return 3'd6;
      OP_LOCK:  return 3'd6;
      default:  return 3'd0;
    endcase
  endfunction

  // data byte of command step idx
  function automatic logic [7:0] cmd_byte(op_e op, logic [2:0] idx, logic [7:0] d);
    case (idx)
      3'd0:    return 8'hAA;
      3'd1:    return 8'h55;
      3'd2:    return (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3:    return (op == OP_PROG) ? d : 8'hAA;
      3'd4:    return 8'h55;
      default: return (op == OP_ERASE) ? 8'h10 : 8'h40;
    endcase
  endfunction

  // step idx writes to the target address instead of a code address
  function automatic logic cmd_to_target(op_e op, logic [2:0] idx);
    return (op == OP_PROG) && (idx == 3'd3);
  endfunction

  // step idx uses the second unlock address
  function automatic logic cmd_uses_b(logic [2:0] idx);
    return (idx == 3'd1) || (idx == 3'd4);
  endfunction

  // programming would need some bit raised from 0 to 1
  function automatic logic needs_raise(logic [7:0] cur, logic [7:0] want);
    return |(want & ~cur);
  endfunction

  // completion seen on bit 7
  function automatic logic poll_match(op_e op, logic [7:0] rd, logic [7:0] d);
    return rd[7] == ((op == OP_ERASE) ? 1'b1 : d[7]);
  endfunction

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  op_e          op,
  input  logic [2:0]   idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]   tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]   cmd_data,
  output logic         cmd_last
);
  always_comb begin
    if (cmd_to_target(op, idx))
      cmd_addr = tgt_addr;
    else if (cmd_uses_b(idx))
      cmd_addr = AW'(CODE_ADDR_B);
    else
      cmd_addr = AW'(CODE_ADDR_A);
    cmd_data = cmd_byte(op, idx, tgt_data);
    cmd_last = (idx == cmd_len(op) - 3'd1);
  end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
  parameter int AW      = 20,
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          idle,
  output logic          done,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                            : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] SU_LAST = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] PW_LAST = CW'(T_PULSE - 1);
  localparam logic [CW-1:0] HO_LAST = CW'(T_HOLD - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      rdata     <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase     <= PH_SETUP;
          cnt       <= '0;
          wr_q      <= is_write;
          fl_addr   <= addr;
          fl_dq_out <= wdata;
        end
        PH_SETUP: begin
          if (cnt == SU_LAST) begin phase <= PH_STROBE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_STROBE: begin
          if (cnt == PW_LAST) begin
            phase <= PH_HOLD;
            cnt   <= '0;
            if (!wr_q) rdata <= fl_dq_in;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == HO_LAST) begin phase <= PH_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign idle     = (phase == PH_IDLE);
  assign done     = (phase == PH_HOLD) && (cnt == HO_LAST);
  assign fl_ce_n  = idle;
  assign fl_we_n  = !((phase == PH_STROBE) && wr_q);
  assign fl_oe_n  = !((phase == PH_STROBE) && !wr_q);
  assign fl_dq_oe = !idle && wr_q;
endmodule

// File: rtl/flash_poll_counter.sv
module flash_poll_counter #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int T_SETUP   = 1,
  parameter int T_PULSE   = 2,
  parameter int T_HOLD    = 1,
  parameter int MAX_POLLS = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic [1:0]    rsp_err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_CMD, S_POLL, S_RSP} st_e;

  st_e           st;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    idx;

  logic          bus_idle, bus_done, bus_start, bus_wr;
  logic [7:0]    bus_rdata;
  logic [AW-1:0] bus_addr, tbl_addr;
  logic [7:0]    tbl_data;
  logic          tbl_last, poll_last;

  // named events for the checker
  logic evt_accept, evt_raise_reject, evt_poll_hit, evt_poll_limit;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign evt_accept       = req_ready && req_valid;
  assign evt_raise_reject = (st == S_READ) && bus_done && (op_q == OP_PROG) &&
                            needs_raise(bus_rdata, data_q);
  assign evt_poll_hit     = (st == S_POLL) && bus_done && poll_match(op_q, bus_rdata, data_q);
  assign evt_poll_limit   = (st == S_POLL) && bus_done && poll_last;

  assign bus_wr    = (st == S_CMD);
  assign bus_start = bus_idle && ((st == S_READ) || (st == S_CMD) || (st == S_POLL));
  assign bus_addr  = bus_wr ? tbl_addr : addr_q;

  flash_cmd_table #(.AW(AW)) u_tbl (
    .op(op_q), .idx(idx), .tgt_addr(addr_q), .tgt_data(data_q),
    .cmd_addr(tbl_addr), .cmd_data(tbl_data), .cmd_last(tbl_last)
  );

  flash_bus_cycle #(.AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_write(bus_wr),
    .addr(bus_addr), .wdata(tbl_data), .idle(bus_idle), .done(bus_done),
    .rdata(bus_rdata), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  flash_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(st != S_POLL),
    .inc((st == S_POLL) && bus_done), .last(poll_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_READ;
      addr_q   <= '0;
      data_q   <= '0;
      idx      <= '0;
      rsp_data <= '0;
      rsp_err  <= ERR_NONE;
    end else begin
      case (st)
        S_IDLE: if (evt_accept) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          idx    <= '0;
          st     <= (req_op == OP_ERASE || req_op == OP_LOCK) ? S_CMD : S_READ;
        end
        S_READ: if (bus_done) begin
          rsp_data <= bus_rdata;
          rsp_err  <= evt_raise_reject ? ERR_RAISE : ERR_NONE;
          st       <= (op_q == OP_PROG && !evt_raise_reject) ? S_CMD : S_RSP;
        end
        S_CMD: if (bus_done) begin
          if (!tbl_last) idx <= idx + 3'd1;
          else if (op_q == OP_LOCK) begin
            rsp_data <= 8'h00;
            rsp_err  <= ERR_NONE;
            st       <= S_RSP;
          end else st <= S_POLL;
        end
        S_POLL: if (bus_done) begin
          rsp_data <= bus_rdata;
          if (evt_poll_hit) begin
            rsp_err <= ERR_NONE;
            st      <= S_RSP;
          end else if (evt_poll_limit) begin
            rsp_err <= ERR_TIMEOUT;
            st      <= S_RSP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_err,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic          evt_raise_reject,
  input logic          evt_poll_hit,
  input logic          evt_poll_limit
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R2
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R2
  AST_DQ_RELEASE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe); // R3
  AST_DQ_RELEASE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ce_n |-> !fl_dq_oe); // R3
  AST_WRITE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $stable(fl_addr) && $stable(fl_dq_out) && $past(fl_dq_oe)); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> fl_dq_oe && $stable(fl_addr) && $stable(fl_dq_out)); // R4
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_raise_reject |=> rsp_valid && fl_we_n && rsp_err == 2'd1); // R7
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_poll_hit |=> rsp_valid && rsp_err == 2'd0); // R8
  AST_POLL_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_poll_limit && !evt_poll_hit) |=> rsp_valid && rsp_err == 2'd2); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_NO_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
endmodule

bind flash_seq flash_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
  .evt_raise_reject(evt_raise_reject), .evt_poll_hit(evt_poll_hit),
  .evt_poll_limit(evt_poll_limit)
);

// File: tb/tb_flash_seq.sv
`timescale 1ns/1ps
module tb_flash_seq;
  localparam int AW = 16;
  localparam int MP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic [1:0] rsp_err;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;
  logic fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

  always #2 clk = ~clk;

  flash_seq #(.AW(AW), .T_SETUP(1), .T_PULSE(2), .T_HOLD(1), .MAX_POLLS(MP)) dut (.*);

  // ---- flash model ----
  logic [7:0] mem [int];
  int  busy_left = 0, busy_len = 0;
  logic busy_bit = 1'b0, prog_arm = 1'b0;
  int  wr_n = 0, rd_n = 0, viol = 0;
  logic [15:0] la [16];
  logic [7:0]  ld [16];
  logic [7:0]  dq_drive = 8'hFF;
  assign fl_dq_in = dq_drive;

  function automatic logic [7:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(negedge clk) begin
    dq_drive <= (busy_left > 0) ? {busy_bit, 7'h00} : mem_rd(int'(fl_addr));
    if (rst_n && ((!fl_we_n && !fl_oe_n) || (!fl_oe_n && fl_dq_oe) ||
                  (fl_ce_n && (fl_dq_oe || !fl_we_n || !fl_oe_n)))) viol++;
  end

  always @(posedge fl_we_n) if (rst_n && !fl_ce_n) begin
    if (wr_n < 16) begin la[wr_n] = 16'(fl_addr); ld[wr_n] = fl_dq_out; end
    wr_n++;
    if (prog_arm) begin
      mem[int'(fl_addr)] = mem_rd(int'(fl_addr)) & fl_dq_out;
      busy_left = busy_len; busy_bit = ~fl_dq_out[7]; prog_arm = 1'b0;
    end else if (fl_addr == 16'h5555 && fl_dq_out == 8'hA0) prog_arm = 1'b1;
    else if (fl_addr == 16'h5555 && fl_dq_out == 8'h10) begin
      mem.delete(); busy_left = busy_len; busy_bit = 1'b0;
    end
  end

  always @(posedge fl_oe_n) if (rst_n && !fl_ce_n) begin
    rd_n++;
    if (busy_left > 0) busy_left--;
  end

  // ---- checking ----
  int n_cmp = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_req(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                        output logic [1:0] err, output logic [7:0] rd);
    @(negedge clk);
    wr_n = 0; rd_n = 0;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R10 ready low while busy", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    err = rsp_err; rd = rsp_data;
    chk(!req_ready, "R10 ready low during rsp", req_ready, 0);
    @(negedge clk);
    chk(!rsp_valid, "R10 single rsp pulse", rsp_valid, 0);
  endtask

  task automatic chk_unlock_train(input string req, input logic [7:0] last_d);
    logic [15:0] ea [6];
    logic [7:0]  ed [6];
    ea = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
    ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, last_d};
    chk_eq({req, " write count"}, wr_n, 6);
    for (int k = 0; k < 6; k++) begin
      chk_eq({req, " addr"}, la[k], ea[k]);
      chk_eq({req, " data"}, ld[k], ed[k]);
    end
  endtask

  task automatic chk_prog_train(input logic [15:0] a, input logic [7:0] d);
    chk_eq("R5 write count", wr_n, 4);
    chk(la[0] == 16'h5555 && ld[0] == 8'hAA, "R5 step0", {la[0], ld[0]}, 24'h5555AA);
    chk(la[1] == 16'h2AAA && ld[1] == 8'h55, "R5 step1", {la[1], ld[1]}, 24'h2AAA55);
    chk(la[2] == 16'h5555 && ld[2] == 8'hA0, "R5 step2", {la[2], ld[2]}, 24'h5555A0);
    chk(la[3] == a && ld[3] == d, "R5 step3", {la[3], ld[3]}, {a, d});
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] e;
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk_eq("R10 reset ready", req_ready, 1);
    chk_eq("R10 reset rsp_valid", rsp_valid, 0);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R2 reset strobes high", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk_eq("R3 reset bus released", fl_dq_oe, 0);
    rst_n = 1'b1;

    // R1: read of erased location
    do_req(2'd0, 16'h0123, 8'h00, e, r);
    chk_eq("R1 read err", e, 0); chk_eq("R1 read data", r, 8'hFF);
    chk_eq("R1 read count", rd_n, 1); chk_eq("R1 no writes", wr_n, 0);

    // R6 + R8: chip erase with two busy polls
    busy_len = 2;
    do_req(2'd2, 16'h0040, 8'h00, e, r);
    chk_unlock_train("R6 erase", 8'h10);
    chk_eq("R8 erase err", e, 0); chk_eq("R8 erase poll reads", rd_n, 3);
    chk_eq("R8 erase last byte", r, 8'hFF);

    // R6: lockout, no polling
    do_req(2'd3, 16'h0000, 8'h00, e, r);
    chk_unlock_train("R6 lockout", 8'h40);
    chk_eq("R6 lockout err", e, 0); chk_eq("R6 lockout data", r, 0);
    chk_eq("R6 lockout no reads", rd_n, 0);

    // R5 + R8: single program, detailed train
    busy_len = 1;
    do_req(2'd1, 16'h0777, 8'h3C, e, r);
    chk_prog_train(16'h0777, 8'h3C);
    chk_eq("R8 prog err", e, 0); chk_eq("R8 prog reads", rd_n, 1 + 2);

    // R7 / R5 / R1 sweep over old x new nibble patterns
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        logic [15:0] a;
        logic [7:0] ob, nb;
        bit raise;
        a  = 16'(16'h1000 + o * 16 + n);
        ob = {4'(o), 4'(o)};
        nb = {4'(n), 4'(n)};
        raise = (nb & ~ob) != 8'h00;
        busy_len = (o + n) % 4;
        do_req(2'd1, a, ob, e, r);
        chk_eq("R5 first program err", e, 0);
        do_req(2'd1, a, nb, e, r);
        if (raise) begin
          chk_eq("R7 refuse err", e, 1); chk_eq("R7 refuse data", r, ob);
          chk_eq("R7 refuse no writes", wr_n, 0); chk_eq("R7 refuse reads", rd_n, 1);
        end else begin
          chk_eq("R5 second program err", e, 0);
          chk_eq("R5 second program writes", wr_n, 4);
          chk_eq("R8 poll reads", rd_n, 1 + busy_len + 1);
        end
        do_req(2'd0, a, 8'h00, e, r);
        chk_eq("R1 readback", r, raise ? ob : (ob & nb));
      end
    end

    // R8 boundary: match on the last allowed poll
    busy_len = MP - 1;
    do_req(2'd1, 16'h2000, 8'h5A, e, r);
    chk_eq("R8 last-poll match err", e, 0);
    chk_eq("R8 last-poll reads", rd_n, 1 + MP);
    chk_eq("R8 last-poll data", r, 8'h5A);

    // R9 boundary: one busy read too many
    busy_len = MP;
    do_req(2'd1, 16'h2001, 8'hA5, e, r);
    chk_eq("R9 timeout err", e, 2);
    chk_eq("R9 timeout reads", rd_n, 1 + MP);
    busy_left = 0;

    // R9: erase that never completes
    busy_len = 1000;
    do_req(2'd2, 16'h0000, 8'h00, e, r);
    chk_eq("R9 erase timeout err", e, 2);
    chk_eq("R9 erase timeout reads", rd_n, MP);
    busy_left = 0;

    chk_eq("R2 R3 R4 bus rule violations", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule